// File: doc/BRIEF.md
# Flash Programming Command Controller

This block holds the command registers for on-chip nonvolatile memory and runs the sequence that carries out program and erase operations on a small internal word array. Software uses a simple register bus to load a target word address, up to four data words and an operation code. It then arms the operation with an enable bit and a two-word key handshake, and sets a start bit. The start bit stays set while the operation runs, so software polls it as a busy flag. Hardware clears it when the operation is over.

The sequencer has four states. `S_IDLE` waits for the start bit. `S_CHECK` decodes the operation into a word range and checks that range against the per-page write-protect inputs. `S_RUN` counts a fixed number of cycles and watches the low-voltage input. `S_FINISH` writes the array if the operation is clean, reports the result to the flags and returns to `S_IDLE`.

Erased words read as all ones, and the array powers up erased. A program operation overwrites the selected words.

Register offsets on `bus_addr`:

| Offset | Register | Contents |
|---|---|---|
| 0x0 | Control | bit 15 start/busy, bit 14 enable, bit 13 write-error, bit 12 low-voltage error, bits 3:0 operation code; all other bits read as 0 |
| 0x1 | Address | word index |
| 0x2 | Key | write-only, reads as 0 |
| 0x4 to 0x7 | Data | data words 0 to 3 |
| 0x8 | Array window | read-only; returns the array word at the address register |

Top module: `flash_prog_ctrl`

## Requirements
- R1: After power-on reset (`por_n` low), the control register reads 0x00000000 and every array word reads 0xFFFFFFFF.
- R2: A system reset (`sys_rst_n` low, with `por_n` high) clears the operation code, the address register, the data registers and the key state. It leaves the start, enable and both error bits unchanged.
- R3: A control write sets the start bit only if all of the following hold: written bits 15 and 14 are both 1; the stored enable bit is already 1; and the two bus accesses just before it were a write of 0x3C5A0F1E to the key register followed by a write of 0xC3A5F0E1 to it. Without all of these the start bit stays 0.
- R4: Any bus access (read or write) between the two key writes cancels the unlock. An unlock permits at most one start; a second start write without new key writes leaves the start bit at 0.
- R5: Operation codes are 0 no-op, 1 word program, 2 quad-word program, 3 row program, 4 page erase, 5 lower-region erase, 6 upper-region erase, 7 erase all. Writes to the code field take effect only while the stored enable bit is 0.
- R6: Once set, the start bit reads 1 for exactly OP_CYCLES+3 clock cycles, then hardware clears it.
- R7: While the start bit is 1, bus writes to the address, data and control registers have no effect.
- R8: Word program writes data 0 to the addressed word. Quad-word program writes the 4-aligned group of words, each word i receiving data (i mod 4). Row program writes the ROW_WORDS-aligned row with the same data pattern.
- R9: Page erase sets every word of the PAGE_WORDS-aligned page holding the address to 0xFFFFFFFF and leaves other pages unchanged.
- R10: A program or page erase that touches a page whose `wp_mask` bit is 1 leaves the array unchanged and sets the write-error bit.
- R11: Codes 5, 6 and 7 each erase the whole array, but only when no `wp_mask` bit is 1; otherwise the array is unchanged and the write-error bit is set.
- R12: Codes 8 to 15, including the chip-erase code 14, set the write-error bit and leave the array unchanged.
- R13: If `low_volt` is 1 in any counting cycle, the operation leaves the array unchanged and sets both error bits. An operation that completes cleanly clears both error bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | Other reset sources, active low, asynchronous |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`; combinational, and valid without `bus_sel` |
| wp_mask | input | WORDS/PAGE_WORDS | Write-protect bit for each page |
| low_volt | input | 1 | Low-voltage indication |

## Verification
The hardest state to reach from the ports is an armed start that must fail. Examples are a key pair broken by a single intervening read, a second start that reuses a spent unlock, and a low-voltage pulse that lands inside the counting window. The bench drives every bus cycle from tasks, so the exact access order is under its control. It reads status without asserting `bus_sel`, because a real read would itself cancel a pending unlock. It holds `low_volt` across the whole busy interval, and it checks the array through the read window after each operation.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

    // register offsets
    localparam logic [3:0] REG_CTRL = 4'h0;
    localparam logic [3:0] REG_ADDR = 4'h1;
    localparam logic [3:0] REG_KEY  = 4'h2;
    localparam logic [3:0] REG_WIN  = 4'h8;

    // unlock constants
    localparam logic [31:0] KEY_FIRST  = 32'h3C5A_0F1E;
    localparam logic [31:0] KEY_SECOND = 32'hC3A5_F0E1;

    // control bit positions
    localparam int B_START = 15;
    localparam int B_EN    = 14;
    localparam int B_WERR  = 13;
    localparam int B_LVERR = 12;

    // operation codes
    localparam logic [3:0] OP_NONE  = 4'd0;
    localparam logic [3:0] OP_WORD  = 4'd1;
    localparam logic [3:0] OP_QUAD  = 4'd2;
    localparam logic [3:0] OP_ROW   = 4'd3;
    localparam logic [3:0] OP_PAGE  = 4'd4;
    localparam logic [3:0] OP_LOWER = 4'd5;
    localparam logic [3:0] OP_UPPER = 4'd6;
    localparam logic [3:0] OP_ALL   = 4'd7;

    typedef enum logic [1:0] {
        S_IDLE,
        S_CHECK,
        S_RUN,
        S_FINISH
    } seq_state_e;

    typedef enum logic [1:0] {
        K_LOCKED,
        K_HALF,
        K_OPEN
    } key_state_e;

endpackage

// File: rtl/flash_prog_regs.sv
module flash_prog_regs
    import flash_prog_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [3:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       win_data,
    input  logic              done,
    input  logic              fail_in,
    input  logic              lv_in,
    output logic              start_q,
    output logic              en_q,
    output logic              werr_q,
    output logic              lverr_q,
    output logic [3:0]        op_q,
    output logic [AW-1:0]     addr_q,
    output logic [3:0][31:0]  data_q
);

    key_state_e key_q, key_d;
    logic       soft_rst_n;
    logic       wr_any;
    logic       ctrl_wr;
    logic       go_ok;

    assign soft_rst_n = por_n & sys_rst_n;
    assign wr_any     = bus_sel & bus_we;
    assign ctrl_wr    = wr_any && (bus_addr == REG_CTRL);
    assign go_ok      = (key_q == K_OPEN) && en_q &&
                        bus_wdata[B_START] && bus_wdata[B_EN];

    // unlock tracking: every access moves the key state
    always_comb begin
        key_d = K_LOCKED;
        if (wr_any && bus_addr == REG_KEY) begin
            if (key_q == K_HALF && bus_wdata == KEY_SECOND)
                key_d = K_OPEN;
            else if (bus_wdata == KEY_FIRST)
                key_d = K_HALF;
        end
    end

    // bits kept across non-power-on resets
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            start_q <= 1'b0;
            en_q    <= 1'b0;
            werr_q  <= 1'b0;
            lverr_q <= 1'b0;
        end else if (done) begin
            start_q <= 1'b0;
            werr_q  <= fail_in;
            lverr_q <= lv_in;
        end else if (ctrl_wr && !start_q) begin
            en_q <= bus_wdata[B_EN];
            if (go_ok)
                start_q <= 1'b1;
        end
    end

    // fields cleared by any reset
    always_ff @(posedge clk or negedge soft_rst_n) begin
        if (!soft_rst_n) begin
            key_q  <= K_LOCKED;
            op_q   <= OP_NONE;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            if (bus_sel)
                key_q <= key_d;
            if (wr_any && !start_q) begin
                if (bus_addr == REG_CTRL && !en_q)
                    op_q <= bus_wdata[3:0];
                if (bus_addr == REG_ADDR)
                    addr_q <= bus_wdata[AW-1:0];
                if (bus_addr[3:2] == 2'b01)
                    data_q[bus_addr[1:0]] <= bus_wdata;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == REG_CTRL) begin
            bus_rdata[B_START] = start_q;
            bus_rdata[B_EN]    = en_q;
            bus_rdata[B_WERR]  = werr_q;
            bus_rdata[B_LVERR] = lverr_q;
            bus_rdata[3:0]     = op_q;
        end else if (bus_addr == REG_ADDR) begin
            bus_rdata[AW-1:0] = addr_q;
        end else if (bus_addr[3:2] == 2'b01) begin
            bus_rdata = data_q[bus_addr[1:0]];
        end else if (bus_addr == REG_WIN) begin
            bus_rdata = win_data;
        end
    end

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
    import flash_prog_pkg::*;
#(
    parameter int WORDS      = 64,
    parameter int PAGE_WORDS = 16,
    parameter int ROW_WORDS  = 8,
    parameter int OP_CYCLES  = 6,
    localparam int AW        = $clog2(WORDS),
    localparam int PAGES     = WORDS / PAGE_WORDS,
    localparam int CW        = $clog2(OP_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              start,
    input  logic [3:0]        op,
    input  logic [AW-1:0]     addr,
    input  logic [3:0][31:0]  data_in,
    input  logic [PAGES-1:0]  wp_mask,
    input  logic              low_volt,
    output seq_state_e        state,
    output logic              done,
    output logic              fail,
    output logic              lv_seen,
    output logic              mem_we,
    output logic [AW-1:0]     mem_lo,
    output logic [AW-1:0]     mem_hi,
    output logic              mem_erase,
    output logic              mem_single,
    output logic [3:0][31:0]  mem_data
);

    seq_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;

    // decode results for the current request
    logic    wr_c, erase_c, single_c, bad_c, prot_c;
    int      lo_i, hi_i;

    // latched request
    logic    wr_q, fail_q, lv_q;

    always_comb begin
        int a;
        a        = int'(addr);
        wr_c     = 1'b1;
        erase_c  = 1'b0;
        single_c = 1'b0;
        bad_c    = 1'b0;
        lo_i     = a;
        hi_i     = a;
        unique case (op)
            OP_NONE: wr_c = 1'b0;
            OP_WORD: single_c = 1'b1;
            OP_QUAD: begin
                lo_i = (a / 4) * 4;
                hi_i = lo_i + 3;
            end
            OP_ROW: begin
                lo_i = (a / ROW_WORDS) * ROW_WORDS;
                hi_i = lo_i + ROW_WORDS - 1;
            end
            OP_PAGE: begin
                lo_i    = (a / PAGE_WORDS) * PAGE_WORDS;
                hi_i    = lo_i + PAGE_WORDS - 1;
                erase_c = 1'b1;
            end
            OP_LOWER, OP_UPPER, OP_ALL: begin
                lo_i    = 0;
                hi_i    = WORDS - 1;
                erase_c = 1'b1;
            end
            default: begin
                wr_c  = 1'b0;
                bad_c = 1'b1;
            end
        endcase
    end

    // any protected page overlapping the range blocks the request
    always_comb begin
        prot_c = 1'b0;
        for (int p = 0; p < PAGES; p++) begin
            if (wr_c && wp_mask[p] && (p * PAGE_WORDS <= hi_i) &&
                (p * PAGE_WORDS + PAGE_WORDS - 1 >= lo_i))
                prot_c = 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = S_CHECK;
            S_CHECK:  state_d = S_RUN;
            S_RUN:    if (cnt_q == CW'(OP_CYCLES - 1)) state_d = S_FINISH;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // request latches and cycle counter
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q      <= '0;
            wr_q       <= 1'b0;
            fail_q     <= 1'b0;
            lv_q       <= 1'b0;
            mem_lo     <= '0;
            mem_hi     <= '0;
            mem_erase  <= 1'b0;
            mem_single <= 1'b0;
            mem_data   <= '0;
        end else begin
            unique case (state_q)
                S_CHECK: begin
                    cnt_q      <= '0;
                    lv_q       <= 1'b0;
                    wr_q       <= wr_c;
                    fail_q     <= bad_c | prot_c;
                    mem_lo     <= lo_i[AW-1:0];
                    mem_hi     <= hi_i[AW-1:0];
                    mem_erase  <= erase_c;
                    mem_single <= single_c;
                    mem_data   <= data_in;
                end
                S_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (low_volt)
                        lv_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        state   = state_q;
        done    = (state_q == S_FINISH);
        fail    = fail_q | lv_q;
        lv_seen = lv_q;
        mem_we  = done && wr_q && !fail_q && !lv_q;
    end

endmodule

// File: rtl/flash_prog_array.sv
module flash_prog_array #(
    parameter int WORDS = 64,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              we,
    input  logic [AW-1:0]     lo,
    input  logic [AW-1:0]     hi,
    input  logic              erase,
    input  logic              single,
    input  logic [3:0][31:0]  wdata,
    input  logic [AW-1:0]     raddr,
    output logic [31:0]       rdata
);

    logic [31:0] mem [WORDS];

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            for (int i = 0; i < WORDS; i++)
                mem[i] <= '1;
        end else if (we) begin
            for (int i = 0; i < WORDS; i++) begin
                if (i >= int'(lo) && i <= int'(hi)) begin
                    if (erase)
                        mem[i] <= '1;
                    else if (single)
                        mem[i] <= wdata[0];
                    else
                        mem[i] <= wdata[i[1:0]];
                end
            end
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
    import flash_prog_pkg::*;
#(
    parameter int WORDS      = 64,
    parameter int PAGE_WORDS = 16,
    parameter int ROW_WORDS  = 8,
    parameter int OP_CYCLES  = 6,
    localparam int AW        = $clog2(WORDS),
    localparam int PAGES     = WORDS / PAGE_WORDS
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [3:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [PAGES-1:0]  wp_mask,
    input  logic              low_volt
);

    logic             start_q, en_q, werr_q, lverr_q;
    logic [3:0]       op_q;
    logic [AW-1:0]    addr_q;
    logic [3:0][31:0] data_q;
    logic [31:0]      win_data;
    seq_state_e       seq_state;
    logic             done, fail, lv_seen;
    logic             mem_we, mem_erase, mem_single;
    logic [AW-1:0]    mem_lo, mem_hi;
    logic [3:0][31:0] mem_data;

    flash_prog_regs #(.AW(AW)) u_regs (
        .clk       (clk),
        .por_n     (por_n),
        .sys_rst_n (sys_rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .win_data  (win_data),
        .done      (done),
        .fail_in   (fail),
        .lv_in     (lv_seen),
        .start_q   (start_q),
        .en_q      (en_q),
        .werr_q    (werr_q),
        .lverr_q   (lverr_q),
        .op_q      (op_q),
        .addr_q    (addr_q),
        .data_q    (data_q)
    );

    flash_prog_seq #(
        .WORDS      (WORDS),
        .PAGE_WORDS (PAGE_WORDS),
        .ROW_WORDS  (ROW_WORDS),
        .OP_CYCLES  (OP_CYCLES)
    ) u_seq (
        .clk        (clk),
        .por_n      (por_n),
        .start      (start_q),
        .op         (op_q),
        .addr       (addr_q),
        .data_in    (data_q),
        .wp_mask    (wp_mask),
        .low_volt   (low_volt),
        .state      (seq_state),
        .done       (done),
        .fail       (fail),
        .lv_seen    (lv_seen),
        .mem_we     (mem_we),
        .mem_lo     (mem_lo),
        .mem_hi     (mem_hi),
        .mem_erase  (mem_erase),
        .mem_single (mem_single),
        .mem_data   (mem_data)
    );

    flash_prog_array #(.WORDS(WORDS)) u_array (
        .clk    (clk),
        .por_n  (por_n),
        .we     (mem_we),
        .lo     (mem_lo),
        .hi     (mem_hi),
        .erase  (mem_erase),
        .single (mem_single),
        .wdata  (mem_data),
        .raddr  (addr_q),
        .rdata  (win_data)
    );

endmodule

// File: rtl/flash_prog_checker.sv
module flash_prog_checker
    import flash_prog_pkg::*;
#(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          por_n,
    input logic          sys_rst_n,
    input logic          start_q,
    input logic          en_q,
    input logic          werr_q,
    input logic          lverr_q,
    input logic [3:0]    op_q,
    input logic [AW-1:0] addr_q,
    input seq_state_e    seq_state,
    input logic          lv_seen
);

    // R3: a start only rises when enable was already stored
    a_r3_start_needs_enable: assert property (@(posedge clk) disable iff (!por_n)
        $rose(start_q) |-> $past(en_q));

    // R5: the code field holds while enable is set
    a_r5_op_locked: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        en_q |=> $stable(op_q));

    // R6: the finishing state releases the busy flag
    a_r6_finish_clears_start: assert property (@(posedge clk) disable iff (!por_n)
        (seq_state == S_FINISH) |=> !start_q);

    // R7: the address is frozen while busy
    a_r7_addr_frozen: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        start_q |=> $stable(addr_q));

    // R13: a low-voltage run ends with both error flags set
    a_r13_lv_flags: assert property (@(posedge clk) disable iff (!por_n)
        (seq_state == S_FINISH && lv_seen) |=> (werr_q && lverr_q));

endmodule

bind flash_prog_ctrl flash_prog_checker #(.AW(AW)) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .sys_rst_n (sys_rst_n),
    .start_q   (start_q),
    .en_q      (en_q),
    .werr_q    (werr_q),
    .lverr_q   (lverr_q),
    .op_q      (op_q),
    .addr_q    (addr_q),
    .seq_state (seq_state),
    .lv_seen   (lv_seen)
);

// File: tb/sim_flash_prog_ctrl.sv
module sim_flash_prog_ctrl;

    localparam int OPC = 6;
    localparam logic [31:0] KA = 32'h3C5A_0F1E;
    localparam logic [31:0] KB = 32'hC3A5_F0E1;
    localparam logic [31:0] ONES = 32'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        sys_rst_n = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  wp_mask = '0;
    logic        low_volt = 1'b0;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    flash_prog_ctrl #(.OP_CYCLES(OPC)) u0 (
        .clk       (clk),
        .por_n     (por_n),
        .sys_rst_n (sys_rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wp_mask   (wp_mask),
        .low_volt  (low_volt)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk);
        #1 bus_sel = 1'b0;
    endtask

    // status look without a bus access
    task automatic peek(logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic mem_word(int idx, output logic [31:0] d);
        wr(4'h1, 32'(idx));
        peek(4'h8, d);
    endtask

    task automatic arm(logic [3:0] op);
        wr(4'h0, {28'h0, op});
        wr(4'h0, 32'h4000 | {28'h0, op});
        wr(4'h2, KA);
        wr(4'h2, KB);
    endtask

    task automatic wait_done(output int cyc);
        logic [31:0] v;
        cyc = 0;
        for (int k = 0; k < 100; k++) begin
            peek(4'h0, v);
            if (!v[15]) break;
            cyc++;
        end
        wr(4'h0, 32'h0);
    endtask

    task automatic run_op(logic [3:0] op, int addr);
        int c;
        wr(4'h1, 32'(addr));
        arm(op);
        wr(4'h0, 32'hC000);
        wait_done(c);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        peek(4'h0, v);
        chk("R1 ctrl", v, 32'h0);
        mem_word(13, v);
        chk("R1 array erased", v, ONES);
    endtask

    task automatic t_op_lock;
        logic [31:0] v;
        wr(4'h0, 32'h0001);
        wr(4'h0, 32'h4001);
        wr(4'h0, 32'h4002);
        peek(4'h0, v);
        chk("R5 op locked", v, 32'h4001);
        wr(4'h0, 32'h0);
    endtask

    task automatic t_unlock;
        logic [31:0] v;
        int c;
        wr(4'h0, 32'h4000);
        wr(4'h0, 32'hC000);
        peek(4'h0, v);
        chk("R3 no key", v[15], 0);
        wr(4'h2, KA);
        rd(4'h0, v);
        wr(4'h2, KB);
        wr(4'h0, 32'hC000);
        peek(4'h0, v);
        chk("R4 broken key", v[15], 0);
        wr(4'h0, 32'h0);
        wr(4'h2, KA);
        wr(4'h2, KB);
        wr(4'h0, 32'hC000);
        peek(4'h0, v);
        chk("R3 key without stored enable", v[15], 0);
        arm(4'h0);
        wr(4'h0, 32'hC000);
        wait_done(c);
        chk("R6 busy cycles", 32'(c), 32'(OPC + 3));
        wr(4'h0, 32'h4000);
        wr(4'h0, 32'hC000);
        peek(4'h0, v);
        chk("R4 unlock spent", v[15], 0);
        wr(4'h0, 32'h0);
    endtask

    task automatic t_word_busy_writes;
        logic [31:0] v;
        int c;
        wr(4'h4, 32'h1234_5678);
        wr(4'h1, 32'd5);
        arm(4'h1);
        wr(4'h0, 32'hC000);
        wr(4'h1, 32'd10);
        wr(4'h4, 32'h0000_DEAD);
        wr(4'h0, 32'hC003);
        wait_done(c);
        peek(4'h1, v);
        chk("R7 address kept", v, 32'd5);
        peek(4'h4, v);
        chk("R7 data kept", v, 32'h1234_5678);
        peek(4'h0, v);
        chk("R7 op kept", v[3:0], 32'h1);
        mem_word(5, v);
        chk("R8 word", v, 32'h1234_5678);
        mem_word(4, v);
        chk("R8 word neighbour", v, ONES);
    endtask

    task automatic t_quad_row;
        logic [31:0] v;
        wr(4'h4, 32'hA000_0000);
        wr(4'h5, 32'hA000_0001);
        wr(4'h6, 32'hA000_0002);
        wr(4'h7, 32'hA000_0003);
        run_op(4'h2, 9);
        mem_word(8, v);  chk("R8 quad w8", v, 32'hA000_0000);
        mem_word(11, v); chk("R8 quad w11", v, 32'hA000_0003);
        mem_word(12, v); chk("R8 quad beyond", v, ONES);
        run_op(4'h3, 19);
        mem_word(16, v); chk("R8 row w16", v, 32'hA000_0000);
        mem_word(23, v); chk("R8 row w23", v, 32'hA000_0003);
        mem_word(24, v); chk("R8 row beyond", v, ONES);
    endtask

    task automatic t_page;
        logic [31:0] v;
        run_op(4'h4, 20);
        mem_word(16, v); chk("R9 page w16", v, ONES);
        mem_word(23, v); chk("R9 page w23", v, ONES);
        mem_word(5, v);  chk("R9 other page", v, 32'h1234_5678);
    endtask

    task automatic t_protect;
        logic [31:0] v;
        wp_mask = 4'b0001;
        wr(4'h4, 32'h5555_AAAA);
        run_op(4'h1, 3);
        mem_word(3, v); chk("R10 protected word", v, ONES);
        peek(4'h0, v);  chk("R10 error flag", v[13], 1);
        run_op(4'h0, 0);
        peek(4'h0, v);  chk("R13 clean clears", v[13:12], 0);
        run_op(4'h7, 0);
        mem_word(5, v); chk("R11 blocked erase", v, 32'h1234_5678);
        peek(4'h0, v);  chk("R11 error flag", v[13], 1);
        wp_mask = 4'b0000;
        run_op(4'h6, 0);
        mem_word(5, v); chk("R11 region erase w5", v, ONES);
        mem_word(8, v); chk("R11 region erase w8", v, ONES);
        peek(4'h0, v);  chk("R11 clean", v[13], 0);
    endtask

    task automatic t_reserved;
        logic [31:0] v;
        wr(4'h4, 32'h0BAD_F00D);
        run_op(4'h1, 2);
        wr(4'h4, 32'h1111_2222);
        run_op(4'h9, 2);
        peek(4'h0, v);  chk("R12 reserved flag", v[13], 1);
        run_op(4'hE, 2);
        peek(4'h0, v);  chk("R12 chip erase flag", v[13], 1);
        mem_word(2, v); chk("R12 array kept", v, 32'h0BAD_F00D);
    endtask

    task automatic t_low_volt;
        logic [31:0] v;
        low_volt = 1'b1;
        run_op(4'h1, 30);
        low_volt = 1'b0;
        mem_word(30, v); chk("R13 no write", v, ONES);
        peek(4'h0, v);   chk("R13 both flags", v[13:12], 2'b11);
        run_op(4'h0, 0);
        peek(4'h0, v);   chk("R13 cleared", v[13:12], 0);
    endtask

    task automatic t_sys_reset;
        logic [31:0] v;
        wp_mask = 4'b0001;
        run_op(4'h1, 0);
        wp_mask = 4'b0000;
        wr(4'h1, 32'd7);
        wr(4'h0, 32'h0003);
        wr(4'h0, 32'h4003);
        @(negedge clk);
        sys_rst_n = 1'b0;
        @(negedge clk);
        sys_rst_n = 1'b1;
        peek(4'h0, v); chk("R2 ctrl after sys reset", v, 32'h6000);
        peek(4'h1, v); chk("R2 address cleared", v, 32'h0);
        wr(4'h0, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 por_n = 1'b1;
        t_reset();
        t_op_lock();
        t_unlock();
        t_word_busy_writes();
        t_quad_row();
        t_page();
        t_protect();
        t_reserved();
        t_low_volt();
        t_sys_reset();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule